// File: doc/BRIEF.md
# Clock Generator Power State Sequencer

This controller brings a clock generator from supply ramp to running outputs and takes it into and out of power-down. After the supply-ok flag rises it lets a settling delay pass before it looks at the active-low power-good strobe. Once that strobe has been low for a hold time, it captures the frequency-select and current-multiplier straps a single time. It then turns on the VCO/PLL, waits for lock and opens the output gates. From that point the strobe has no further effect until the supply drops.

The active-low power-down pin is asynchronous and passes through a synchronizer. While the block is running, a low on this pin first closes every output gate, then keeps the PLL on for a drain window so that each group finishes its low phase, and then turns the PLL off. Releasing the pin turns the PLL back on. The gates reopen once lock returns. Each output group has its own gate cell. The cell retimes the enable on the falling edge of that group's clock, so a gate only changes while its clock is low. All millisecond delays are counted in ticks of a parameterised prescaler.

Named states and transitions: OFF goes to SETTLE when supply is good. SETTLE goes to WAIT_PG when the settle time has elapsed. WAIT_PG goes to HOLD when the strobe is seen low. HOLD goes back to WAIT_PG if the strobe goes high, or to SAMPLE when the hold time has elapsed. SAMPLE goes to LOCK after one cycle. LOCK goes to RUN on lock with power-down released, or to PDOWN on power-down. RUN goes to DRAIN on power-down. DRAIN goes to PDOWN when the drain time has elapsed. PDOWN goes to LOCK on release. Any state goes to OFF on supply loss.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: During and right after reset, pll_en, every gate_en bit, fs_latched and mult_latched are all 0.
- R2: After supply_ok rises, power-good is disregarded for SETTLE_TICKS*TICK_DIV cycles, even if it is already low.
- R3: power-good passes through two synchronizer flops. It must then stay low for HOLD_TICKS*TICK_DIV cycles before sampling happens. If it rises during that hold, the hold restarts from the wait state.
- R4: The straps are captured once, in the single SAMPLE cycle. After that, fs_latched and mult_latched stay constant through later strap changes and power-good toggles until the supply is lost.
- R5: pll_en is 1 exactly in LOCK, RUN and DRAIN. The outputs are requested only in RUN, and RUN is entered only with lock present and power-down released.
- R6: Each gate_en bit changes only while its own group clock is low. It follows the request after two falling edges of that clock, so it is still 0 in the cycle in which RUN is entered.
- R7: power-down passes through two flops. A synchronized low in RUN drops the output request at once and keeps pll_en at 1 for DRAIN_TICKS*TICK_DIV+1 cycles. All gates are closed by the time pll_en falls.
- R8: Releasing power-down in PDOWN turns pll_en on again. The gates reopen only after the synchronized lock is seen.
- R9: When supply_ok is 0 at a clock edge, the next cycle shows OFF behaviour: pll_en 0 and both latched strap fields 0.
- R10: A synchronized power-down seen in LOCK goes straight to PDOWN, with no drain window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Analog supply above threshold (synchronous) |
| pgood_n | input | 1 | Active-low power-good strobe, asynchronous |
| pdown_n | input | 1 | Active-low power-down request, asynchronous |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| strap_fs | input | FS_W | Frequency-select strap levels |
| strap_mult | input | 2 | Current-multiplier strap levels |
| grp_clk | input | NGRP | Clock of each output group |
| fs_latched | output | FS_W | Captured frequency straps |
| mult_latched | output | 2 | Captured multiplier straps |
| pll_en | output | 1 | VCO/PLL enable |
| gate_en | output | NGRP | Per-group output gate enable |

## Verification
A wrong state shows up first on pll_en and on the latched strap fields. The reference model compares these on every clock, so a state that is entered early, entered late or skipped is caught in the cycle it happens. Counting errors in the settle, hold or drain windows move the pll_en edges by whole ticks. A premature RUN, or a gate that opens while its clock is high, appears on gate_en within one group clock period. Straps that are lost or captured again show up as a mismatch on fs_latched in the next cycle.

// File: rtl/clkgen_pwr_pkg.sv
`timescale 1ns/1ps
package clkgen_pwr_pkg;
    typedef enum logic [3:0] {
        ST_OFF     = 4'd0,
        ST_SETTLE  = 4'd1,
        ST_WAIT_PG = 4'd2,
        ST_HOLD    = 4'd3,
        ST_SAMPLE  = 4'd4,
        ST_LOCK    = 4'd5,
        ST_RUN     = 4'd6,
        ST_DRAIN   = 4'd7,
        ST_PDOWN   = 4'd8
    } pseq_state_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return $clog2(m + 2);
    endfunction
endpackage

// File: rtl/clkgen_bit_sync.sv
`timescale 1ns/1ps
module clkgen_bit_sync #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/clkgen_tick_timer.sv
`timescale 1ns/1ps
module clkgen_tick_timer #(
    parameter int unsigned TICK_DIV = 250,
    parameter int unsigned CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] ticks
);
    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] TICK_MAX = '1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            ticks_q <= '0;
        end else if (clear) begin
            div_q   <= '0;
            ticks_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (ticks_q != TICK_MAX) begin
                ticks_q <= ticks_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign ticks = ticks_q;
endmodule

// File: rtl/clkgen_gate_cell.sv
`timescale 1ns/1ps
module clkgen_gate_cell (
    input  logic grp_clk,
    input  logic rst_n,
    input  logic en_req,
    output logic gate
);
    logic stage_q;
    logic gate_q;

    // both flops move on the falling edge, so gate changes only in the low phase
    always_ff @(negedge grp_clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            gate_q  <= 1'b0;
        end else begin
            stage_q <= en_req;
            gate_q  <= stage_q;
        end
    end

    assign gate = gate_q;
endmodule

// File: rtl/clkgen_pseq_fsm.sv
`timescale 1ns/1ps
module clkgen_pseq_fsm
    import clkgen_pwr_pkg::*;
#(
    parameter int unsigned FS_W         = 5,
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned SETTLE_TICKS = 1146,
    parameter int unsigned HOLD_TICKS   = 250,
    parameter int unsigned DRAIN_TICKS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             pg_low,
    input  logic             pd_ok,
    input  logic             lock_ok,
    input  logic [FS_W-1:0]  strap_fs,
    input  logic [1:0]       strap_mult,
    input  logic [CNT_W-1:0] ticks,
    output logic             timer_clear,
    output logic [FS_W-1:0]  fs_latched,
    output logic [1:0]       mult_latched,
    output logic             pll_en,
    output logic             run_req
);
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_TICKS);
    localparam logic [CNT_W-1:0] HOLD_LIM   = CNT_W'(HOLD_TICKS);
    localparam logic [CNT_W-1:0] DRAIN_LIM  = CNT_W'(DRAIN_TICKS);

    pseq_state_t state_q, state_d;
    logic [FS_W-1:0] fs_q;
    logic [1:0]      mult_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (supply_ok) state_d = ST_SETTLE;
            ST_SETTLE:  if (ticks >= SETTLE_LIM) state_d = ST_WAIT_PG;
            ST_WAIT_PG: if (pg_low) state_d = ST_HOLD;
            ST_HOLD: begin
                if (!pg_low) begin
                    state_d = ST_WAIT_PG;
                end else if (ticks >= HOLD_LIM) begin
                    state_d = ST_SAMPLE;
                end
            end
            ST_SAMPLE:  state_d = ST_LOCK;
            ST_LOCK: begin
                if (!pd_ok) begin
                    state_d = ST_PDOWN;
                end else if (lock_ok) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN:     if (!pd_ok) state_d = ST_DRAIN;
            ST_DRAIN:   if (ticks >= DRAIN_LIM) state_d = ST_PDOWN;
            ST_PDOWN:   if (pd_ok) state_d = ST_LOCK;
            default:    state_d = ST_OFF;
        endcase
        if (!supply_ok) begin
            state_d = ST_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q   <= '0;
            mult_q <= '0;
        end else if (!supply_ok) begin
            fs_q   <= '0;
            mult_q <= '0;
        end else if (state_q == ST_SAMPLE) begin
            fs_q   <= strap_fs;
            mult_q <= strap_mult;
        end
    end

    always_comb begin
        pll_en  = 1'b0;
        run_req = 1'b0;
        unique case (state_q)
            ST_LOCK, ST_DRAIN: pll_en = 1'b1;
            ST_RUN: begin
                pll_en  = 1'b1;
                run_req = 1'b1;
            end
            default: begin
                pll_en  = 1'b0;
                run_req = 1'b0;
            end
        endcase
    end

    assign timer_clear  = (state_d != state_q);
    assign fs_latched   = fs_q;
    assign mult_latched = mult_q;
endmodule

// File: rtl/clkgen_pwr_seq.sv
`timescale 1ns/1ps
module clkgen_pwr_seq
    import clkgen_pwr_pkg::*;
#(
    parameter int unsigned FS_W         = 5,
    parameter int unsigned NGRP         = 4,
    parameter int unsigned TICK_DIV     = 250,
    parameter int unsigned SETTLE_TICKS = 1146,
    parameter int unsigned HOLD_TICKS   = 250,
    parameter int unsigned DRAIN_TICKS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            supply_ok,
    input  logic            pgood_n,
    input  logic            pdown_n,
    input  logic            pll_lock,
    input  logic [FS_W-1:0] strap_fs,
    input  logic [1:0]      strap_mult,
    input  logic [NGRP-1:0] grp_clk,
    output logic [FS_W-1:0] fs_latched,
    output logic [1:0]      mult_latched,
    output logic            pll_en,
    output logic [NGRP-1:0] gate_en
);
    localparam int unsigned CNT_W = cnt_width(SETTLE_TICKS, HOLD_TICKS, DRAIN_TICKS);

    logic pg_sync_n;
    logic pd_ok_s;
    logic lock_s;
    logic timer_clear;
    logic run_req;
    logic [CNT_W-1:0] ticks;

    clkgen_bit_sync #(.RST_VAL(1'b1)) u_pg_sync (
        .clk(clk), .rst_n(rst_n), .d(pgood_n), .q(pg_sync_n)
    );
    clkgen_bit_sync #(.RST_VAL(1'b1)) u_pd_sync (
        .clk(clk), .rst_n(rst_n), .d(pdown_n), .q(pd_ok_s)
    );
    clkgen_bit_sync #(.RST_VAL(1'b0)) u_lock_sync (
        .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
    );

    clkgen_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(timer_clear), .ticks(ticks)
    );

    clkgen_pseq_fsm #(
        .FS_W(FS_W), .CNT_W(CNT_W), .SETTLE_TICKS(SETTLE_TICKS),
        .HOLD_TICKS(HOLD_TICKS), .DRAIN_TICKS(DRAIN_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_low(~pg_sync_n),
        .pd_ok(pd_ok_s), .lock_ok(lock_s), .strap_fs(strap_fs),
        .strap_mult(strap_mult), .ticks(ticks), .timer_clear(timer_clear),
        .fs_latched(fs_latched), .mult_latched(mult_latched),
        .pll_en(pll_en), .run_req(run_req)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        clkgen_gate_cell u_cell (
            .grp_clk(grp_clk[g]), .rst_n(rst_n), .en_req(run_req), .gate(gate_en[g])
        );
    end
endmodule

// File: rtl/clkgen_pwr_seq_chk.sv
`timescale 1ns/1ps
module clkgen_pwr_seq_chk #(
    parameter int unsigned FS_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            supply_ok,
    input logic            pll_en,
    input logic            run_req,
    input logic            pd_ok_s,
    input logic [FS_W-1:0] fs_latched
);
    // R9
    supply_loss_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (fs_latched == '0 && !pll_en));

    // R4
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && $past(pll_en) && supply_ok && $past(supply_ok)) |-> $stable(fs_latched));

    // R5
    run_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |-> pll_en);

    // R5
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_req) |-> pd_ok_s);

    // R7
    drain_keeps_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run_req) && supply_ok) |-> pll_en);
endmodule

bind clkgen_pwr_seq clkgen_pwr_seq_chk #(.FS_W(FS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pll_en(pll_en),
    .run_req(run_req), .pd_ok_s(pd_ok_s), .fs_latched(fs_latched)
);

// File: tb/tb_clkgen_pwr_seq.sv
`timescale 1ns/1ps
module tb_clkgen_pwr_seq;
    localparam int FS_W = 5;
    localparam int NGRP = 4;
    localparam int TDIV = 4;
    localparam int SETL = 5;
    localparam int HOLD = 3;
    localparam int DRN  = 6;

    localparam int M_OFF = 0, M_SETTLE = 1, M_WAIT = 2, M_HOLD = 3, M_SAMPLE = 4,
                   M_LOCK = 5, M_RUN = 6, M_DRAIN = 7, M_PDOWN = 8;

    logic clk = 0, rst_n = 0, supply_ok = 0, pgood_n = 1, pdown_n = 1, pll_lock = 0;
    logic [FS_W-1:0] strap_fs = 5'h0A;
    logic [1:0] strap_mult = 2'b10;
    logic [NGRP-1:0] grp_clk = '0;
    logic [FS_W-1:0] fs_latched;
    logic [1:0] mult_latched;
    logic pll_en;
    logic [NGRP-1:0] gate_en;

    int total = 0, bad = 0;
    bit timeout = 0;

    clkgen_pwr_seq #(.FS_W(FS_W), .NGRP(NGRP), .TICK_DIV(TDIV), .SETTLE_TICKS(SETL),
        .HOLD_TICKS(HOLD), .DRAIN_TICKS(DRN)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pgood_n(pgood_n),
        .pdown_n(pdown_n), .pll_lock(pll_lock), .strap_fs(strap_fs),
        .strap_mult(strap_mult), .grp_clk(grp_clk), .fs_latched(fs_latched),
        .mult_latched(mult_latched), .pll_en(pll_en), .gate_en(gate_en));

    always #2 clk = ~clk;
    always #4  grp_clk[0] = ~grp_clk[0];
    always #6  grp_clk[1] = ~grp_clk[1];
    always #8  grp_clk[2] = ~grp_clk[2];
    always #15 grp_clk[3] = ~grp_clk[3];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st = M_OFF, m_cyc = 0, nx;
    bit pg1 = 1, pg2 = 1, pd1 = 1, pd2 = 1, lk1 = 0, lk2 = 0;
    int m_fs = 0, m_mult = 0;
    bit prev_pll = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_OFF; m_cyc = 0; pg1 = 1; pg2 = 1; pd1 = 1; pd2 = 1;
            lk1 = 0; lk2 = 0; m_fs = 0; m_mult = 0;
        end else begin
            nx = m_st;
            case (m_st)
                M_OFF:    if (supply_ok) nx = M_SETTLE;
                M_SETTLE: if (m_cyc >= SETL * TDIV) nx = M_WAIT;
                M_WAIT:   if (!pg2) nx = M_HOLD;
                M_HOLD:   if (pg2) nx = M_WAIT; else if (m_cyc >= HOLD * TDIV) nx = M_SAMPLE;
                M_SAMPLE: nx = M_LOCK;
                M_LOCK:   if (!pd2) nx = M_PDOWN; else if (lk2) nx = M_RUN;
                M_RUN:    if (!pd2) nx = M_DRAIN;
                M_DRAIN:  if (m_cyc >= DRN * TDIV) nx = M_PDOWN;
                M_PDOWN:  if (pd2) nx = M_LOCK;
                default:  nx = M_OFF;
            endcase
            if (!supply_ok) nx = M_OFF;
            if (!supply_ok) begin m_fs = 0; m_mult = 0; end
            else if (m_st == M_SAMPLE) begin m_fs = int'(strap_fs); m_mult = int'(strap_mult); end
            m_cyc = (nx != m_st) ? 0 : m_cyc + 1;
            m_st = nx;
            pg2 = pg1; pg1 = pgood_n; pd2 = pd1; pd1 = pdown_n; lk2 = lk1; lk1 = pll_lock;
        end
    end

    function automatic bit m_pll();
        return (m_st == M_LOCK || m_st == M_RUN || m_st == M_DRAIN);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            chk(pll_en == m_pll(), "R5", "pll_en vs model", int'(pll_en), int'(m_pll()));
            chk(int'(fs_latched) == m_fs, "R4", "fs_latched vs model", int'(fs_latched), m_fs);
            chk(int'(mult_latched) == m_mult, "R4", "mult_latched vs model",
                int'(mult_latched), m_mult);
            if (prev_pll && !pll_en && supply_ok)
                chk(gate_en == '0, "R7", "gates closed when PLL stops", int'(gate_en), 0);
            prev_pll = pll_en;
        end
    end

    // R6: any gate change must happen while its own clock is low
    for (genvar g = 0; g < NGRP; g++) begin : g_edge
        always @(gate_en[g]) begin
            if (rst_n) chk(grp_clk[g] == 1'b0, "R6", "gate changed with clock high",
                           int'(grp_clk[g]), 0);
        end
    end

    task automatic wait_model(input int st, input int max_cyc, input string req);
        int n = 0;
        while (m_st != st && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
        chk(m_st == st, req, "model state reached", m_st, st);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_test();
        // R1 reset values
        cycles(3);
        chk(pll_en == 0 && gate_en == '0, "R1", "pll/gates in reset", int'({pll_en, gate_en}), 0);
        chk(fs_latched == '0 && mult_latched == '0, "R1", "straps in reset",
            int'(fs_latched), 0);
        rst_n = 1;
        cycles(2);
        chk(pll_en == 0 && gate_en == '0, "R1", "after reset", int'({pll_en, gate_en}), 0);

        // R2: power-good already low during settle is disregarded
        pgood_n = 0;
        supply_ok = 1;
        cycles(SETL * TDIV - 2);
        chk(m_st == M_SETTLE, "R2", "still settling", m_st, M_SETTLE);
        chk(pll_en == 0 && fs_latched == '0, "R2", "nothing sampled in settle",
            int'(fs_latched), 0);
        pgood_n = 1;
        wait_model(M_WAIT, 20, "R2");

        // R3: short low pulse aborts hold
        pgood_n = 0;
        cycles(5);
        pgood_n = 1;
        cycles(6);
        chk(m_st == M_WAIT, "R3", "hold aborted", m_st, M_WAIT);
        chk(fs_latched == '0, "R3", "no sample after aborted hold", int'(fs_latched), 0);

        // R3/R4: real strobe, sample once
        pgood_n = 0;
        wait_model(M_SAMPLE, 40, "R3");
        cycles(1);
        chk(fs_latched == 5'h0A && mult_latched == 2'b10, "R4", "straps captured",
            int'(fs_latched), 10);
        strap_fs = 5'h13;
        strap_mult = 2'b01;
        pgood_n = 1;
        cycles(4);
        pgood_n = 0;
        cycles(4);
        chk(fs_latched == 5'h0A, "R4", "later straps ignored", int'(fs_latched), 10);

        // R5/R6: lock then run; gates open only after two falling edges
        cycles(5);
        chk(pll_en == 1 && gate_en == '0, "R5", "lock wait, gates shut", int'(gate_en), 0);
        pll_lock = 1;
        wait_model(M_RUN, 10, "R5");
        chk(gate_en == '0, "R6", "gates still closed on RUN entry", int'(gate_en), 0);
        cycles(20);
        chk(gate_en == '1, "R6", "all gates open", int'(gate_en), 15);

        // R7: power-down with drain
        pdown_n = 0;
        wait_model(M_DRAIN, 6, "R7");
        cycles(DRN * TDIV - 1);
        chk(pll_en == 1, "R7", "PLL on through drain", int'(pll_en), 1);
        wait_model(M_PDOWN, 4, "R7");
        chk(pll_en == 0 && gate_en == '0, "R7", "powered down", int'({pll_en, gate_en}), 0);

        // R8: release with lock lost
        pll_lock = 0;
        cycles(3);
        pdown_n = 1;
        wait_model(M_LOCK, 6, "R8");
        cycles(20);
        chk(pll_en == 1 && gate_en == '0, "R8", "waiting for relock", int'(gate_en), 0);
        pll_lock = 1;
        wait_model(M_RUN, 6, "R8");
        cycles(20);
        chk(gate_en == '1, "R8", "gates reopened", int'(gate_en), 15);

        // R10: power-down during LOCK skips drain
        pdown_n = 0;
        wait_model(M_PDOWN, 40, "R7");
        pll_lock = 0;
        pdown_n = 1;
        wait_model(M_LOCK, 6, "R10");
        pdown_n = 0;
        cycles(3);
        chk(m_st == M_PDOWN && pll_en == 0, "R10", "direct to power-down",
            int'(pll_en), 0);
        pdown_n = 1;
        pll_lock = 1;
        wait_model(M_RUN, 12, "R10");
        cycles(20);

        // R9: supply loss clears everything, then a fresh power-up samples new straps
        supply_ok = 0;
        cycles(1);
        chk(pll_en == 0 && fs_latched == '0 && mult_latched == '0, "R9", "supply loss",
            int'(fs_latched), 0);
        cycles(20);
        chk(gate_en == '0, "R9", "gates closed after supply loss", int'(gate_en), 0);
        supply_ok = 1;
        wait_model(M_SAMPLE, 60, "R9");
        cycles(1);
        chk(fs_latched == 5'h13 && mult_latched == 2'b01, "R4", "new straps after re-power",
            int'(fs_latched), 19);
        wait_model(M_RUN, 10, "R5");
        cycles(20);
        chk(gate_en == '1, "R6", "gates open after re-power", int'(gate_en), 15);
    endtask

    initial begin
        fork
            run_test();
            begin
                #800000;
                timeout = 1;
            end
        join_any
        if (timeout) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule